// File: doc/BRIEF.md
# Display Command Decoder and Address Pointer

This block sits behind the serial byte receiver of a character-and-segment LCD controller. Each accepted byte arrives with a flag that marks it as a command or as display data. The block decodes it, keeps a 6-bit address pointer into a 48-location display memory (character codes and cursor cells at low addresses, free-form 5-dot segment patterns at 0x20 to 0x2F), holds the controller's mode settings, and issues single-cycle write strobes to three stores: a character-code RAM, a 3-bit per-address attribute RAM and a 5-bit per-dot blink RAM for the segment rows.

The pointer advances on its own only after data bytes and after the attribute commands; an explicit increment command first applies the stored load option to the current cell (blank it, or clear its cursor and blink state, or both). The display scan, the font lookup and the serial front end live elsewhere.

Top module: `lcdc_cmd_core`

## Requirements
- R1: A synchronous reset sets the pointer to 0x00, the load option to 00, and clears display-on, blink pattern, 1-dot blink unit and per-bit blink entry; no write strobe is active in the cycle after reset.
- R2: A command 11aaaaaa loads the pointer with aaaaaa (any value 0x00 to 0x3F) and issues no write.
- R3: A data byte at a pointer below 0x30 (with per-bit entry not in effect) writes the byte to the code RAM at the pointer and advances the pointer; 0x2F advances to 0x00.
- R4: With the pointer at 0x30 to 0x3F, data bytes and attribute commands issue no write and leave the pointer unchanged; the increment command issues no write and advances the pointer modulo 64.
- R5: A command 0xxx s1 s0 v x writes v to the attribute bits chosen by s1s0 at the pointer and advances it; attribute bit 0 is character blink, bit 1 cursor on, bit 2 cursor blink; s1s0=00 selects bit 0, 01 bit 1, 10 bit 2, 11 bits 0 and 2.
- R6: The increment command (100x1x1x) applies the load option to the pointer's cell before advancing: option bit 0 writes the blank code 0x20 to the code RAM, option bit 1 writes 0 to all three attribute bits and, at 0x20 to 0x2F, writes 0 to the blink RAM; option 00 writes nothing. Command 1011xxpq sets the option to pq.
- R7: Mode commands 100x b3 b2 b1 d set a setting to d without moving the pointer or writing: b3..b1=000 bank select, 001 blink pattern, 011 serial-out enable, 100 display on; with b3..b1=110, bit 4 = 1 sets the 1-dot blink unit and bit 4 = 0 sets per-bit blink entry.
- R8: Per-bit entry is in effect only when both per-bit entry and the 1-dot unit are set; then a data byte at 0x20 to 0x2F writes bits 4..0 to the blink RAM at offset pointer minus 0x20, a data byte at 0x00 to 0x1F writes nothing, and both advance the pointer; otherwise data goes to the code RAM.
- R9: Reset leaves bank select and serial-out enable unchanged.
- R10: Commands 1010xxxx and 100x010x are no-operations: no write, no setting changed, pointer unchanged.
- R11: Every write strobe lasts one cycle and appears in the cycle after the accepting byte_valid; with no byte_valid, no strobe appears and unused address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A byte is present this cycle |
| byte_is_cmd | input | 1 | 1 = command byte, 0 = display data |
| byte_in | input | 8 | Byte value |
| ptr | output | 6 | Address pointer |
| disp_on | output | 1 | Display enabled |
| blink_pat | output | 1 | Blink pattern select |
| so_en | output | 1 | Serial-out enable |
| bank_sel | output | 1 | Bank select |
| blink_unit_1dot | output | 1 | Segment blink in 1-dot units |
| bit_blink_entry | output | 1 | Per-bit blink entry requested |
| load_opt | output | 2 | Load option applied on increment |
| code_we | output | 1 | Code RAM write strobe |
| code_addr | output | 6 | Code RAM address |
| code_wdata | output | 8 | Code RAM data |
| attr_we | output | 1 | Attribute RAM write strobe |
| attr_addr | output | 6 | Attribute RAM address |
| attr_mask | output | 3 | Attribute bits being written |
| attr_wdata | output | 3 | Attribute bit values |
| blink_we | output | 1 | Blink RAM write strobe |
| blink_addr | output | 4 | Blink RAM offset within segment rows |
| blink_wdata | output | 5 | Blink RAM data |

## Verification
On every cycle the assertions check the reset state, that a pointer load takes the command's low six bits, that out-of-range data leaves the pointer and the RAMs untouched, that mode commands never move the pointer or strobe, that attribute values follow the command's value bit, that blink RAM data writes only happen in 1-dot entry, and that no strobe appears without a byte. Only the bench's scenarios show the exact addresses and data of each write, the 0x2F wrap, the load-option combinations, the 5-dot fallback of data to the code RAM, the no-operation encodings and that bank select and serial-out enable survive reset.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W   = 6;
    localparam int BYTE_W   = 8;
    localparam int ATTR_W   = 3;
    localparam int SEG_BITS = 5;

    // attribute bit positions
    localparam int ATTR_CHAR_BLINK = 0;
    localparam int ATTR_CURSOR     = 1;
    localparam int ATTR_CUR_BLINK  = 2;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LOAD_PTR,
        OP_LOAD_OPT,
        OP_BANK,
        OP_SO_EN,
        OP_DISP,
        OP_PATTERN,
        OP_UNIT,
        OP_ENTRY,
        OP_STEP,
        OP_ATTR,
        OP_DATA
    } op_e;

    typedef struct packed {
        op_e                     op;
        logic                    flag;
        logic [ADDR_W-1:0]       arg;
        logic [ATTR_W-1:0]       amask;
    } dec_t;

    typedef struct packed {
        logic                    code_we;
        logic [ADDR_W-1:0]       code_addr;
        logic [BYTE_W-1:0]       code_wdata;
        logic                    attr_we;
        logic [ADDR_W-1:0]       attr_addr;
        logic [ATTR_W-1:0]       attr_mask;
        logic [ATTR_W-1:0]       attr_wdata;
        logic                    blink_we;
        logic [3:0]              blink_addr;
        logic [SEG_BITS-1:0]     blink_wdata;
    } wr_t;

    function automatic logic [ATTR_W-1:0] attr_select(input logic [1:0] sel);
        logic [ATTR_W-1:0] m;
        m = '0;
        unique case (sel)
            2'b00: m[ATTR_CHAR_BLINK] = 1'b1;
            2'b01: m[ATTR_CURSOR]     = 1'b1;
            2'b10: m[ATTR_CUR_BLINK]  = 1'b1;
            default: begin
                m[ATTR_CHAR_BLINK] = 1'b1;
                m[ATTR_CUR_BLINK]  = 1'b1;
            end
        endcase
        return m;
    endfunction

    function automatic dec_t decode_byte(input logic is_cmd, input logic [BYTE_W-1:0] b);
        dec_t d;
        d.op    = OP_NOP;
        d.flag  = b[0];
        d.arg   = b[ADDR_W-1:0];
        d.amask = attr_select(b[3:2]);
        if (!is_cmd) begin
            d.op = OP_DATA;
        end else if (b[7:6] == 2'b11) begin
            d.op = OP_LOAD_PTR;
        end else if (b[7:4] == 4'b1011) begin
            d.op = OP_LOAD_OPT;
        end else if (b[7:5] == 3'b100) begin
            unique case (b[3:1])
                3'b000:        d.op = OP_BANK;
                3'b001:        d.op = OP_PATTERN;
                3'b011:        d.op = OP_SO_EN;
                3'b100:        d.op = OP_DISP;
                3'b110:        d.op = b[4] ? OP_UNIT : OP_ENTRY;
                3'b101, 3'b111: d.op = OP_STEP;
                default:       d.op = OP_NOP;
            endcase
        end else if (!b[7]) begin
            d.op   = OP_ATTR;
            d.flag = b[1];
        end
        return d;
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic              is_cmd,
    input  logic [BYTE_W-1:0] byte_in,
    output dec_t              dec
);
    always_comb dec = decode_byte(is_cmd, byte_in);
endmodule

// File: rtl/lcdc_ptr.sv
module lcdc_ptr
    import lcdc_pkg::*;
#(
    parameter int NUM_LOC = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              in_range
);
    localparam int FULL_SPACE = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_LOC - 1);

    logic [ADDR_W-1:0] nxt;

    generate
        if (NUM_LOC >= FULL_SPACE) begin : g_full
            assign in_range = 1'b1;
            assign nxt      = ptr + ADDR_W'(1);
        end else begin : g_part
            assign in_range = (ptr < ADDR_W'(NUM_LOC));
            assign nxt      = (ptr == LAST) ? '0 : ptr + ADDR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= nxt;
    end
endmodule

// File: rtl/lcdc_modes.sv
module lcdc_modes
    import lcdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  op_e        op,
    input  logic       flag,
    input  logic [1:0] opt_val,
    output logic       disp_on,
    output logic       blink_pat,
    output logic       so_en,
    output logic       bank_sel,
    output logic       unit_1dot,
    output logic       entry,
    output logic [1:0] load_opt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_on   <= 1'b0;
            blink_pat <= 1'b0;
            unit_1dot <= 1'b0;
            entry     <= 1'b0;
            load_opt  <= 2'b00;
        end else if (wr) begin
            unique case (op)
                OP_DISP:     disp_on   <= flag;
                OP_PATTERN:  blink_pat <= flag;
                OP_UNIT:     unit_1dot <= flag;
                OP_ENTRY:    entry     <= flag;
                OP_LOAD_OPT: load_opt  <= opt_val;
                default: ;
            endcase
        end
    end

    // these two settings survive reset
    always_ff @(posedge clk) begin
        if (wr && op == OP_BANK)  bank_sel <= flag;
        if (wr && op == OP_SO_EN) so_en    <= flag;
    end
endmodule

// File: rtl/lcdc_cmd_core.sv
module lcdc_cmd_core
    import lcdc_pkg::*;
#(
    parameter int          NUM_LOC    = 48,
    parameter int          SEG_BASE   = 32,
    parameter logic [7:0]  BLANK_CODE = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_valid,
    input  logic                 byte_is_cmd,
    input  logic [7:0]           byte_in,
    output logic [5:0]           ptr,
    output logic                 disp_on,
    output logic                 blink_pat,
    output logic                 so_en,
    output logic                 bank_sel,
    output logic                 blink_unit_1dot,
    output logic                 bit_blink_entry,
    output logic [1:0]           load_opt,
    output logic                 code_we,
    output logic [5:0]           code_addr,
    output logic [7:0]           code_wdata,
    output logic                 attr_we,
    output logic [5:0]           attr_addr,
    output logic [2:0]           attr_mask,
    output logic [2:0]           attr_wdata,
    output logic                 blink_we,
    output logic [3:0]           blink_addr,
    output logic [4:0]           blink_wdata
);
    localparam int SEG_AW = $clog2(NUM_LOC - SEG_BASE);
    localparam logic [ADDR_W-1:0] SEG_START = ADDR_W'(SEG_BASE);

    dec_t              dec;
    logic              in_range;
    logic              in_seg;
    logic              entry_eff;
    logic              ptr_load;
    logic              ptr_step;
    logic [ADDR_W-1:0] seg_diff;
    wr_t               wr_nxt;
    wr_t               wr_q;

    lcdc_decode u_dec (
        .is_cmd  (byte_is_cmd),
        .byte_in (byte_in),
        .dec     (dec)
    );

    assign ptr_load = byte_valid && (dec.op == OP_LOAD_PTR);
    assign ptr_step = byte_valid && ((dec.op == OP_STEP) ||
                      (in_range && (dec.op == OP_ATTR || dec.op == OP_DATA)));

    lcdc_ptr #(.NUM_LOC(NUM_LOC)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (dec.arg),
        .step     (ptr_step),
        .ptr      (ptr),
        .in_range (in_range)
    );

    lcdc_modes u_modes (
        .clk       (clk),
        .rst       (rst),
        .wr        (byte_valid),
        .op        (dec.op),
        .flag      (dec.flag),
        .opt_val   (byte_in[1:0]),
        .disp_on   (disp_on),
        .blink_pat (blink_pat),
        .so_en     (so_en),
        .bank_sel  (bank_sel),
        .unit_1dot (blink_unit_1dot),
        .entry     (bit_blink_entry),
        .load_opt  (load_opt)
    );

    assign in_seg    = in_range && (ptr >= SEG_START);
    assign entry_eff = bit_blink_entry && blink_unit_1dot;
    assign seg_diff  = ptr - SEG_START;

    always_comb begin
        wr_nxt = '0;
        if (byte_valid && in_range) begin
            unique case (dec.op)
                OP_STEP: begin
                    if (load_opt[0]) begin
                        wr_nxt.code_we    = 1'b1;
                        wr_nxt.code_addr  = ptr;
                        wr_nxt.code_wdata = BLANK_CODE;
                    end
                    if (load_opt[1]) begin
                        wr_nxt.attr_we    = 1'b1;
                        wr_nxt.attr_addr  = ptr;
                        wr_nxt.attr_mask  = '1;
                        wr_nxt.attr_wdata = '0;
                        if (in_seg) begin
                            wr_nxt.blink_we   = 1'b1;
                            wr_nxt.blink_addr = 4'(seg_diff[SEG_AW-1:0]);
                        end
                    end
                end
                OP_ATTR: begin
                    wr_nxt.attr_we    = 1'b1;
                    wr_nxt.attr_addr  = ptr;
                    wr_nxt.attr_mask  = dec.amask;
                    wr_nxt.attr_wdata = {ATTR_W{dec.flag}};
                end
                OP_DATA: begin
                    if (!entry_eff) begin
                        wr_nxt.code_we    = 1'b1;
                        wr_nxt.code_addr  = ptr;
                        wr_nxt.code_wdata = byte_in;
                    end else if (in_seg) begin
                        wr_nxt.blink_we    = 1'b1;
                        wr_nxt.blink_addr  = 4'(seg_diff[SEG_AW-1:0]);
                        wr_nxt.blink_wdata = byte_in[SEG_BITS-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_q <= '0;
        else     wr_q <= wr_nxt;
    end

    assign code_we     = wr_q.code_we;
    assign code_addr   = wr_q.code_addr;
    assign code_wdata  = wr_q.code_wdata;
    assign attr_we     = wr_q.attr_we;
    assign attr_addr   = wr_q.attr_addr;
    assign attr_mask   = wr_q.attr_mask;
    assign attr_wdata  = wr_q.attr_wdata;
    assign blink_we    = wr_q.blink_we;
    assign blink_addr  = wr_q.blink_addr;
    assign blink_wdata = wr_q.blink_wdata;
endmodule

// File: rtl/lcdc_cmd_core_chk.sv
module lcdc_cmd_core_chk #(
    parameter int NUM_LOC  = 48,
    parameter int SEG_BASE = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic       byte_is_cmd,
    input logic [7:0] byte_in,
    input logic [5:0] ptr,
    input logic       disp_on,
    input logic       blink_pat,
    input logic       blink_unit_1dot,
    input logic       bit_blink_entry,
    input logic [1:0] load_opt,
    input logic       code_we,
    input logic [5:0] code_addr,
    input logic       attr_we,
    input logic [5:0] attr_addr,
    input logic [2:0] attr_wdata,
    input logic       blink_we
);
    logic mode_byte;
    assign mode_byte = byte_valid && byte_is_cmd && byte_in[7:5] == 3'b100 &&
                       (byte_in[3:1] == 3'b000 || byte_in[3:1] == 3'b001 ||
                        byte_in[3:1] == 3'b011 || byte_in[3:1] == 3'b100 ||
                        byte_in[3:1] == 3'b110);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ptr == 6'd0 && !disp_on && !blink_pat && !blink_unit_1dot &&
                        !bit_blink_entry && load_opt == 2'b00 &&
                        !code_we && !attr_we && !blink_we));

    a_r2_load_ptr: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(byte_valid && byte_is_cmd && byte_in[7:6] == 2'b11))
        |-> (ptr == $past(byte_in[5:0])));

    a_r3_addr_bound: assert property (@(posedge clk) disable iff (rst)
        (code_we || attr_we) |->
        ((!code_we || code_addr < 6'(NUM_LOC)) && (!attr_we || attr_addr < 6'(NUM_LOC))));

    a_r4_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(byte_valid && !byte_is_cmd) && $past(ptr) >= 6'(NUM_LOC))
        |-> (ptr == $past(ptr) && !code_we && !blink_we));

    a_r5_attr_value: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && attr_we && $past(byte_is_cmd) && !$past(byte_in[7]))
        |-> (attr_wdata == {3{$past(byte_in[1])}}));

    a_r7_mode_still: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_byte))
        |-> (ptr == $past(ptr) && !code_we && !attr_we && !blink_we));

    a_r8_blink_source: assert property (@(posedge clk) disable iff (rst)
        (blink_we && !attr_we) |-> (bit_blink_entry && blink_unit_1dot));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_valid) |-> (!code_we && !attr_we && !blink_we));
endmodule

bind lcdc_cmd_core lcdc_cmd_core_chk #(.NUM_LOC(NUM_LOC), .SEG_BASE(SEG_BASE)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .byte_valid      (byte_valid),
    .byte_is_cmd     (byte_is_cmd),
    .byte_in         (byte_in),
    .ptr             (ptr),
    .disp_on         (disp_on),
    .blink_pat       (blink_pat),
    .blink_unit_1dot (blink_unit_1dot),
    .bit_blink_entry (bit_blink_entry),
    .load_opt        (load_opt),
    .code_we         (code_we),
    .code_addr       (code_addr),
    .attr_we         (attr_we),
    .attr_addr       (attr_addr),
    .attr_wdata      (attr_wdata),
    .blink_we        (blink_we)
);

// File: tb/tb_lcdc_cmd_core.sv
module tb_lcdc_cmd_core;

    typedef struct packed {
        logic [5:0] ptr;
        logic       disp;
        logic       pat;
        logic       soe;
        logic       bank;
        logic       unit;
        logic       entry;
        logic [1:0] opt;
        logic       code_we;
        logic [5:0] code_addr;
        logic [7:0] code_wdata;
        logic       attr_we;
        logic [5:0] attr_addr;
        logic [2:0] attr_mask;
        logic [2:0] attr_wdata;
        logic       blink_we;
        logic [3:0] blink_addr;
        logic [4:0] blink_wdata;
    } obs_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_valid = 1'b0;
    logic byte_is_cmd = 1'b0;
    logic [7:0] byte_in = 8'h00;

    logic [5:0] ptr;
    logic disp_on, blink_pat, so_en, bank_sel, blink_unit_1dot, bit_blink_entry;
    logic [1:0] load_opt;
    logic code_we, attr_we, blink_we;
    logic [5:0] code_addr, attr_addr;
    logic [7:0] code_wdata;
    logic [2:0] attr_mask, attr_wdata;
    logic [3:0] blink_addr;
    logic [4:0] blink_wdata;

    always #2.5 clk = ~clk;

    lcdc_cmd_core dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_is_cmd(byte_is_cmd),
        .byte_in(byte_in), .ptr(ptr), .disp_on(disp_on), .blink_pat(blink_pat),
        .so_en(so_en), .bank_sel(bank_sel), .blink_unit_1dot(blink_unit_1dot),
        .bit_blink_entry(bit_blink_entry), .load_opt(load_opt),
        .code_we(code_we), .code_addr(code_addr), .code_wdata(code_wdata),
        .attr_we(attr_we), .attr_addr(attr_addr), .attr_mask(attr_mask),
        .attr_wdata(attr_wdata), .blink_we(blink_we), .blink_addr(blink_addr),
        .blink_wdata(blink_wdata)
    );

    obs_t act;
    assign act = {ptr, disp_on, blink_pat, so_en, bank_sel, blink_unit_1dot, bit_blink_entry,
                  load_opt, code_we, code_addr, code_wdata, attr_we, attr_addr, attr_mask,
                  attr_wdata, blink_we, blink_addr, blink_wdata};

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    obs_t  exp_q[$];
    string tag_q[$];

    // reference state from the requirements
    logic [5:0] m_ptr;
    logic m_disp, m_pat, m_soe = 1'bx, m_bank = 1'bx, m_unit, m_entry;
    logic [1:0] m_opt;

    task automatic check(input string tag, input obs_t a, input obs_t e);
        n_checks++;
        if (a !== e) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    function automatic logic [5:0] nx(input logic [5:0] p);
        if (p == 6'd47) return 6'd0;
        return p + 6'd1;
    endfunction

    function automatic obs_t quiet();
        obs_t e;
        e = '0;
        e.ptr = m_ptr; e.disp = m_disp; e.pat = m_pat; e.soe = m_soe; e.bank = m_bank;
        e.unit = m_unit; e.entry = m_entry; e.opt = m_opt;
        return e;
    endfunction

    // scoreboard driver: compute expectation, push, drive
    task automatic send(input string tag, input bit c, input logic [7:0] b);
        obs_t e;
        bit inr, seg;
        e = '0;
        inr = (m_ptr < 6'd48);
        seg = inr && (m_ptr >= 6'd32);
        if (!c) begin
            if (inr) begin
                if (m_entry && m_unit) begin
                    if (seg) begin
                        e.blink_we = 1; e.blink_addr = 4'(m_ptr - 6'd32); e.blink_wdata = b[4:0];
                    end
                end else begin
                    e.code_we = 1; e.code_addr = m_ptr; e.code_wdata = b;
                end
                m_ptr = nx(m_ptr);
            end
        end else if (b[7:6] == 2'b11) begin
            m_ptr = b[5:0];
        end else if (b[7:4] == 4'hB) begin
            m_opt = b[1:0];
        end else if (b[7:5] == 3'b100) begin
            case (b[3:1])
                3'd0: m_bank = b[0];
                3'd1: m_pat  = b[0];
                3'd3: m_soe  = b[0];
                3'd4: m_disp = b[0];
                3'd6: if (b[4]) m_unit = b[0]; else m_entry = b[0];
                3'd5, 3'd7: begin
                    if (inr) begin
                        if (m_opt[0]) begin
                            e.code_we = 1; e.code_addr = m_ptr; e.code_wdata = 8'h20;
                        end
                        if (m_opt[1]) begin
                            e.attr_we = 1; e.attr_addr = m_ptr; e.attr_mask = 3'b111;
                            if (seg) begin
                                e.blink_we = 1; e.blink_addr = 4'(m_ptr - 6'd32);
                            end
                        end
                        m_ptr = nx(m_ptr);
                    end else begin
                        m_ptr = m_ptr + 6'd1;
                    end
                end
                default: ;
            endcase
        end else if (!b[7]) begin
            if (inr) begin
                e.attr_we = 1; e.attr_addr = m_ptr; e.attr_wdata = {3{b[1]}};
                case (b[3:2])
                    2'b00: e.attr_mask = 3'b001;
                    2'b01: e.attr_mask = 3'b010;
                    2'b10: e.attr_mask = 3'b100;
                    default: e.attr_mask = 3'b101;
                endcase
                m_ptr = nx(m_ptr);
            end
        end
        e.ptr = m_ptr; e.disp = m_disp; e.pat = m_pat; e.soe = m_soe; e.bank = m_bank;
        e.unit = m_unit; e.entry = m_entry; e.opt = m_opt;
        @(negedge clk);
        byte_valid = 1'b1; byte_is_cmd = c; byte_in = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        byte_valid = 1'b0; byte_is_cmd = 1'b0; byte_in = 8'h00;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        idle(2);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_ptr = 6'd0; m_disp = 0; m_pat = 0; m_unit = 0; m_entry = 0; m_opt = 2'b00;
    endtask

    // monitor
    logic fired = 1'b0;
    always @(posedge clk) fired <= byte_valid && !rst;

    always @(negedge clk) begin
        if (fired && exp_q.size() > 0) begin
            obs_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, act, e);
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset state", act, quiet());

        // R7 mode settings
        send("R7 serial-out enable", 1, 8'h87);
        send("R7 bank select 0", 1, 8'h80);
        send("R7 display on", 1, 8'h89);
        send("R7 blink pattern", 1, 8'h83);

        // R2 / R3 data path
        send("R2 load ptr 0x05", 1, 8'hC5);
        send("R3 data at 0x05", 0, 8'h41);
        send("R3 data at 0x06", 0, 8'h42);
        send("R2 load ptr 0x2F", 1, 8'hEF);
        send("R3 data wraps 0x2F", 0, 8'h55);

        // R5 attributes at 0x00..0x03
        send("R5 char blink on", 1, 8'h02);
        send("R5 cursor on", 1, 8'h06);
        send("R5 cursor blink on", 1, 8'h0A);
        send("R5 both blinks off", 1, 8'h0C);

        // R4 out of range
        send("R2 load ptr 0x30", 1, 8'hF0);
        send("R4 data ignored", 0, 8'h11);
        send("R4 attr ignored", 1, 8'h06);
        send("R4 step from 0x30", 1, 8'h8A);
        send("R2 load ptr 0x3F", 1, 8'hFF);
        send("R4 step wraps 0x3F", 1, 8'h8A);

        // R6 load option
        send("R6 option 01", 1, 8'hB1);
        send("R2 load ptr 0x07", 1, 8'hC7);
        send("R6 blank on step", 1, 8'h8A);
        send("R6 option 10", 1, 8'hB2);
        send("R2 load ptr 0x22", 1, 8'hE2);
        send("R6 clear attrs seg", 1, 8'h8A);
        send("R6 option 11", 1, 8'hB3);
        send("R6 both on step", 1, 8'h8E);
        send("R2 load ptr 0x10", 1, 8'hD0);
        send("R6 clear attrs no seg", 1, 8'h8A);
        send("R6 option 00", 1, 8'hB0);
        send("R6 plain step", 1, 8'h9E);

        // R8 per-bit entry
        send("R7 entry on", 1, 8'h8D);
        send("R2 load ptr 0x24", 1, 8'hE4);
        send("R8 5-dot data to code", 0, 8'hE7);
        send("R7 unit 1-dot", 1, 8'h9D);
        send("R8 blink data 0x25", 0, 8'hFF);
        send("R8 blink data 0x26", 0, 8'h0A);
        send("R2 load ptr 0x1F", 1, 8'hDF);
        send("R8 entry below seg", 0, 8'h03);
        send("R7 entry off", 1, 8'h8C);
        send("R8 data back to code", 0, 8'h77);

        // R10 no-operations
        send("R10 nop 1010xxxx", 1, 8'hA5);
        send("R10 nop 100x010x", 1, 8'h84);
        send("R10 nop 100x010x b", 1, 8'h95);

        // R11 idle gap
        idle(3);
        check("R11 no strobe idle", act, quiet());

        // R9 bank/serial-out survive reset
        send("R7 bank select 1", 1, 8'h81);
        do_reset();
        check("R9 bank so_en kept, R1 reset", act, quiet());
        send("R3 data after reset", 0, 8'h30);
        idle(2);
        check("R11 quiet at end", act, quiet());

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule